// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block derives an exact one-microsecond tick from a reference clock whose frequency need not be a whole number of megahertz. A 16-bit ratio setting says that a given number of reference clocks spans a given number of microseconds. A phase accumulator spreads the ticks evenly over that span, so the long-term tick rate matches the ratio exactly.

Every tick advances a free-running microsecond counter that wraps around. Software reaches the block through plain read and write strobes with a byte address. The counter can only be read; the ratio setting can be written and read back. Typical settings are 0x000B for 12 MHz, 0x000C for 13 MHz, 0x0019 for 26 MHz and 0x002F for 48 MHz. Fractional cases include 0x043F for 12.8 MHz (64 clocks per 5 us), 0x0453 for 16.8 MHz, 0x045F for 19.2 MHz and 0x04BF for 38.4 MHz.

Top module: `usec_timebase`

## Requirements
- R1: After reset the ratio setting reads 0x000B, the counter reads 0 and rdata is 0.
- R2: A read with addr = 0x10 loads rdata, at the next clock edge, with the counter value as it stood before that edge, zero-extended. rdata holds its value while rd_en is low.
- R3: A write with addr = 0x14 stores wdata. A later read at 0x14 returns it in rdata bits 15:0, with the upper bits zero.
- R4: Let D be setting bits 7:0 and U be setting bits 15:8. After a ratio write, exactly floor(N*(U+1)/(D+1)) one-cycle pulses appear on usec_tick over the next N clocks when U <= D. The pulse pattern is set by an accumulator that is reset to zero by that write.
- R5: The counter rises by exactly one for each usec_tick pulse, in the cycle after the pulse, and wraps modulo 2^CNT_W (CNT_W is 32 by default).
- R6: A ratio write clears the tick phase: it produces no pulse in the following cycle and leaves the counter value unchanged.
- R7: A write to address 0x10 has no effect on the counter. A read at any address other than 0x10 or 0x14 returns 0.
- R8: When U > D, usec_tick is high on every clock after the write, so there is never more than one tick per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | CFG_W (16) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| usec_tick | output | 1 | One-cycle pulse per microsecond |

## Verification
Counter wrap is the case that is hardest to reach from the ports, because the default 32-bit counter needs billions of ticks before it wraps. The bench therefore builds the block with a 10-bit counter and runs the 1:1 ratio long enough to wrap it several times, always checking modulo arithmetic. Accumulator clearing is exposed in a second way. The bench first leaves a large residue under a 256:1 ratio, then writes the same ratio again and expects no tick in a window that a stale residue would push past the threshold. A near-exhaustive sweep over all small ratio pairs, including out-of-range ones, checks both the pulse count and the counter difference against floor arithmetic.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  localparam int CNT_OFFSET = 32'h10;
  localparam int CFG_OFFSET = 32'h14;
  localparam int FIELD_W    = 8;
  localparam int CFG_W      = 2 * FIELD_W;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h000B;
endpackage

// File: rtl/usec_cfg_regs.sv
module usec_cfg_regs
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  cfg,
  output logic              cfg_load
);
  always_comb cfg_load = wr_en && (addr == ADDR_W'(CFG_OFFSET));

  always_ff @(posedge clk) begin
    if (rst)           cfg <= CFG_RESET;
    else if (cfg_load) cfg <= wdata;
  end

  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> cfg == $past(wdata));
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg));
endmodule

// File: rtl/usec_frac_tick.sv
module usec_frac_tick #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [FIELD_W-1:0] num_m1,
  input  logic [FIELD_W-1:0] den_m1,
  output logic               tick
);
  localparam int ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc, step, limit, sum;
  logic             over, reach;

  always_comb begin
    step  = ACC_W'(num_m1) + ACC_W'(1);
    limit = ACC_W'(den_m1) + ACC_W'(1);
    sum   = acc + step;
    over  = step > limit;
    reach = sum >= limit;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (over) begin
      acc  <= '0;
      tick <= 1'b1;
    end else if (reach) begin
      acc  <= sum - limit;
      tick <= 1'b1;
    end else begin
      acc  <= sum;
      tick <= 1'b0;
    end
  end

  assert_acc_below_den_R4: assert property (@(posedge clk) disable iff (rst)
    acc < limit);
  assert_clear_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tick);
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(count) + CNT_W'(1));
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/usec_readback.sv
module usec_readback
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [CFG_W-1:0]  cfg,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cnt_ext, cfg_ext, sel;
  logic              hit_cnt, hit_cfg;

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = count;
    cfg_ext = '0;
    cfg_ext[CFG_W-1:0] = cfg;
    hit_cnt = addr == ADDR_W'(CNT_OFFSET);
    hit_cfg = addr == ADDR_W'(CFG_OFFSET);
    if (hit_cnt)      sel = cnt_ext;
    else if (hit_cfg) sel = cfg_ext;
    else              sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  assert_read_count_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit_cnt) |=> rdata[CNT_W-1:0] == $past(count));
  assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  assert_read_unmapped_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_cnt && !hit_cfg) |=> rdata == '0);
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              usec_tick
);
  logic [CFG_W-1:0] cfg;
  logic             cfg_load;
  logic [CNT_W-1:0] count;

  usec_cfg_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg(cfg), .cfg_load(cfg_load)
  );

  usec_frac_tick #(.FIELD_W(FIELD_W)) i_tick (
    .clk(clk), .rst(rst), .clear(cfg_load),
    .num_m1(cfg[CFG_W-1:FIELD_W]), .den_m1(cfg[FIELD_W-1:0]),
    .tick(usec_tick)
  );

  usec_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(usec_tick), .count(count)
  );

  usec_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .count(count),
    .cfg(cfg), .rdata(rdata)
  );
endmodule

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int MODV = 1 << CNT_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0;
  logic [31:0] rdata;
  logic        usec_tick;

  int nchk = 0;
  int nfail = 0;

  usec_timebase #(.ADDR_W(8), .DATA_W(32), .CNT_W(CNT_W)) i_usec_timebase (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .usec_tick(usec_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Writes setting c at edge 0, counts pulses after edges 1..n,
  // reads the counter at edge 1 and at edge n+2.
  task automatic measure(input logic [15:0] c, input int n, input bit keep);
    int v, c0, pulses, h, l, e;
    h = int'(c[15:8]) + 1;
    l = int'(c[7:0]) + 1;
    e = (h > l) ? n : (n * h) / l;
    @(negedge clk); addr = 8'h10; rd_en = 1'b1; wr_en = 1'b0;
    @(posedge clk); @(negedge clk); v = int'(rdata);
    addr = 8'h14; wr_en = 1'b1; wdata = c;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; addr = 8'h10;
    @(posedge clk); @(negedge clk); c0 = int'(rdata);
    pulses = int'(usec_tick);
    for (int k = 2; k <= n; k++) begin
      @(posedge clk); @(negedge clk); pulses += int'(usec_tick);
    end
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (h > l) check("R8 pulses out of range", pulses, e);
    else       check("R4 pulse count", pulses, e);
    check("R5 counter advance", int'(rdata), (c0 + e) % MODV);
    if (keep) check("R6 counter kept across write", c0, (v + 2) % MODV);
  endtask

  initial begin
    int v;
    logic [15:0] std_cfg [8];
    std_cfg = '{16'h000B, 16'h043F, 16'h000C, 16'h0453,
                16'h045F, 16'h0019, 16'h04BF, 16'h002F};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 rdata after reset", int'(rdata), 0);
    rd_en = 1'b1; addr = 8'h14;
    @(posedge clk); @(negedge clk);
    check("R1 setting after reset", int'(rdata), 16'h000B);
    addr = 8'h10;
    @(posedge clk); @(negedge clk);
    check("R1 counter after reset", int'(rdata), 0);
    addr = 8'h18;
    @(posedge clk); @(negedge clk);
    check("R7 unmapped read", int'(rdata), 0);
    rd_en = 1'b0; addr = 8'h10;
    @(posedge clk); @(negedge clk);
    check("R2 rdata held without read", int'(rdata), 0);

    foreach (std_cfg[i]) measure(std_cfg[i], 320, 1'b0);

    for (int d = 0; d < 12; d++)
      for (int u = 0; u < 12; u++)
        measure({u[7:0], d[7:0]}, 29, 1'b0);

    // R6: residue left by a slow ratio must be discarded by the rewrite
    measure(16'h00FF, 100, 1'b0);
    measure(16'h00FF, 200, 1'b0);

    // R5: wrap of the counter under 1:1, then R6 continuity
    measure(16'h0000, 1100, 1'b0);
    measure(16'h0000, 2500, 1'b1);
    measure(16'h043F, 200, 1'b1);

    // R3: readback of a written setting
    @(negedge clk); wr_en = 1'b1; addr = 8'h14; wdata = 16'hA5C3; rd_en = 1'b0;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 setting readback", int'(rdata), 16'hA5C3);

    // R7: counter write ignored (1:1 ratio, counter steps every clock)
    measure(16'h0000, 10, 1'b0);
    @(negedge clk); addr = 8'h10; rd_en = 1'b1;
    @(posedge clk); @(negedge clk); v = int'(rdata);
    wr_en = 1'b1; wdata = 16'h0000;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 counter write ignored", int'(rdata), (v + 2) % MODV);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule